// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

The block gives software a register-mapped view of up to four banks of 32 general-purpose pins. Each bank occupies its own 0x200-byte window. The window holds the registers that read the pin levels, set the driven values and output enables, and control a per-pin interrupt engine. Each pin input passes through a two-flop synchronizer. An event detector then compares the synchronized level with its value one cycle earlier. It recognises rising, falling or both edges, or an active-high or active-low level.

Detected events latch into a sticky raw status bit. Software acknowledges an event by writing a one to the matching bit of a write-only clear register. A per-pin enable gates the raw status into a masked status. The masked status of every bank is ORed into one interrupt line. Register accesses use a plain 32-bit select/write bus, and read data is registered one cycle after the request.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Bank b starts at byte address b*0x200. Within a bank, offset 0x04 holds the driven data and offset 0x08 holds the output enable, and both read back as written. pin_out and pin_oe for pin n carry bit n%32 of bank n/32, one cycle after the write.
- R2: Offset 0x00 reads the pin levels after a two-flop synchronizer. Writes to it are ignored.
- R3: The mode bits sit at offset 0x0C (1 = level), 0x10 (1 = both edges) and 0x14 (1 = rising/high). With level=0, both=0 and polarity=1, a rising edge sets the pin's raw status bit at offset 0x1C. The bit stays set after the pin returns low.
- R4: With level=0, both=0 and polarity=0, only a falling edge sets the raw status. A rising edge leaves it clear.
- R5: With level=0 and both=1, either edge sets the raw status, whatever the polarity bit holds.
- R6: With level=1, the raw status bit is set on every cycle the pin sits at its active level (high for polarity 1, low for polarity 0). A clear written while the level is still active does not leave the bit cleared.
- R7: Writing a 1 to a bit at offset 0x24 clears that raw status bit. A 0 leaves the bit unchanged. Offset 0x24 reads as zero.
- R8: Offset 0x18 holds the enables (1 = unmasked). Offset 0x20 reads raw AND enable. irq is the OR of the masked status of all banks.
- R9: If an edge is detected in the same cycle that a clear is written for that bit, the bit stays set.
- R10: Reads of unmapped offsets, or of bank windows beyond NUM_BANKS, return zero. Writes there change nothing, and writes to the raw and masked status offsets are ignored.
- R11: After reset, every register reads zero, pin_out and pin_oe are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (bank index above bit 8) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| pin_out | output | NUM_BANKS*32 | Driven pin values |
| pin_oe | output | NUM_BANKS*32 | Per-pin output enables |
| irq | output | 1 | OR of all masked status bits |

## Verification
The hardest case to reach from the ports is a fresh edge and a software clear landing on the same clock edge for the same status bit. The bench toggles a both-edges pin at a falling clock edge and counts the two synchronizer stages and the detector register. It then issues the clear write so that the bus samples it on the exact edge where the detector reports the new event. A plain clear one cycle later shows the contrast. A level-sensitive pin is also cleared while its level stays active, to show that the status re-asserts at once.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int DATA_W        = 32;
    localparam int OFF_W         = 9;   // 0x200-byte bank window

    typedef enum logic [3:0] {
        REG_DIN,
        REG_DOUT,
        REG_OE,
        REG_LVL,
        REG_BOTH,
        REG_POL,
        REG_EN,
        REG_RAW,
        REG_MSTAT,
        REG_CLR,
        REG_NONE
    } reg_sel_e;

    typedef enum logic [2:0] {
        SENSE_FALL,
        SENSE_RISE,
        SENSE_BOTH,
        SENSE_LOW,
        SENSE_HIGH
    } sense_e;

    typedef struct packed {
        logic [PINS_PER_BANK-1:0] lvl_mode;
        logic [PINS_PER_BANK-1:0] both_edges;
        logic [PINS_PER_BANK-1:0] high_pol;
        logic [PINS_PER_BANK-1:0] enable;
    } irq_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bank_req_t;

    function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off);
        case (off)
            9'h000:  return REG_DIN;
            9'h004:  return REG_DOUT;
            9'h008:  return REG_OE;
            9'h00C:  return REG_LVL;
            9'h010:  return REG_BOTH;
            9'h014:  return REG_POL;
            9'h018:  return REG_EN;
            9'h01C:  return REG_RAW;
            9'h020:  return REG_MSTAT;
            9'h024:  return REG_CLR;
            default: return REG_NONE;
        endcase
    endfunction

    // Level mode overrides the both-edges bit; both-edges overrides polarity.
    function automatic sense_e pin_sense(input logic lvl, input logic both, input logic pol);
        if (lvl)       return pol ? SENSE_HIGH : SENSE_LOW;
        else if (both) return SENSE_BOTH;
        else           return pol ? SENSE_RISE : SENSE_FALL;
    endfunction

endpackage

// File: rtl/gpio_sync_2ff.sv
module gpio_sync_2ff #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PINS_PER_BANK-1:0] level,
    input  irq_cfg_t                 cfg,
    input  logic [PINS_PER_BANK-1:0] clr,
    output logic [PINS_PER_BANK-1:0] status
);

    logic [PINS_PER_BANK-1:0] prev;
    logic [PINS_PER_BANK-1:0] set_vec;

    for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
        sense_e mode;
        logic   rise;
        logic   fall;

        always_comb begin
            mode = pin_sense(cfg.lvl_mode[i], cfg.both_edges[i], cfg.high_pol[i]);
            rise = level[i] & ~prev[i];
            fall = ~level[i] & prev[i];
            case (mode)
                SENSE_RISE: set_vec[i] = rise;
                SENSE_FALL: set_vec[i] = fall;
                SENSE_BOTH: set_vec[i] = rise | fall;
                SENSE_HIGH: set_vec[i] = level[i];
                SENSE_LOW:  set_vec[i] = ~level[i];
                default:    set_vec[i] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            status <= '0;
        end else begin
            prev   <= level;
            status <= (status & ~clr) | set_vec;   // a new event outranks a clear
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~status & $past(status) & ~$past(clr)) == '0)); // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(clr) & ~$past(set_vec)) == '0)); // R7

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec) & ~status) == '0)); // R9

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  bank_req_t                req,
    input  logic [PINS_PER_BANK-1:0] din,
    output logic [DATA_W-1:0]        rdata,
    output logic [PINS_PER_BANK-1:0] dout,
    output logic [PINS_PER_BANK-1:0] oe,
    output logic                     irq_out
);

    irq_cfg_t                 cfg;
    logic [PINS_PER_BANK-1:0] clr;
    logic [PINS_PER_BANK-1:0] raw;
    logic [PINS_PER_BANK-1:0] mstat;
    logic                     wr_hit;

    assign wr_hit = req.valid & req.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            oe   <= '0;
            cfg  <= '0;
        end else if (wr_hit) begin
            case (req.sel)
                REG_DOUT: dout           <= req.wdata;
                REG_OE:   oe             <= req.wdata;
                REG_LVL:  cfg.lvl_mode   <= req.wdata;
                REG_BOTH: cfg.both_edges <= req.wdata;
                REG_POL:  cfg.high_pol   <= req.wdata;
                REG_EN:   cfg.enable     <= req.wdata;
                default: ;
            endcase
        end
    end

    assign clr = (wr_hit && req.sel == REG_CLR) ? req.wdata : '0;

    gpio_evt_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .level  (din),
        .cfg    (cfg),
        .clr    (clr),
        .status (raw)
    );

    assign mstat   = raw & cfg.enable;
    assign irq_out = |mstat;

    always_comb begin
        case (req.sel)
            REG_DIN:   rdata = din;
            REG_DOUT:  rdata = dout;
            REG_OE:    rdata = oe;
            REG_LVL:   rdata = cfg.lvl_mode;
            REG_BOTH:  rdata = cfg.both_edges;
            REG_POL:   rdata = cfg.high_pol;
            REG_EN:    rdata = cfg.enable;
            REG_RAW:   rdata = raw;
            REG_MSTAT: rdata = mstat;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    parameter  int ADDR_W    = 11,
    localparam int NUM_PINS  = NUM_BANKS * PINS_PER_BANK
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int BANK_W = ADDR_W - OFF_W;

    logic [BANK_W-1:0]                bank_idx;
    reg_sel_e                         reg_sel;
    logic [NUM_BANKS-1:0]             bank_hit;
    logic [NUM_BANKS-1:0]             bank_irq;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic [NUM_PINS-1:0]              pin_sync;
    logic [DATA_W-1:0]                rd_sel;
    logic                             rd_zero;

    assign bank_idx = bus_addr[ADDR_W-1:OFF_W];
    assign reg_sel  = decode_offset(bus_addr[OFF_W-1:0]);

    gpio_sync_2ff #(.WIDTH(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_req_t req;

        assign bank_hit[b] = (bank_idx == BANK_W'(b));
        assign req.valid   = bus_sel & bank_hit[b];
        assign req.wr      = bus_wr;
        assign req.sel     = reg_sel;
        assign req.wdata   = bus_wdata;

        gpio_bank_regs u_bank (
            .clk     (clk),
            .rst     (rst),
            .req     (req),
            .din     (pin_sync[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .rdata   (bank_rdata[b]),
            .dout    (pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .oe      (pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .irq_out (bank_irq[b])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) rd_sel = bank_rdata[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_sel;
    end

    assign irq = |bank_irq;

    assign rd_zero = (bank_hit == '0) || (reg_sel == REG_NONE) || (reg_sel == REG_CLR);

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && rd_zero) |=> (bus_rdata == '0)); // R10

    AST_DOUT_REACHES_PIN: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(4)) |=>
            (pin_out[PINS_PER_BANK-1:0] == $past(bus_wdata))); // R1

endmodule

// File: tb/gpio_banked_ctrl_test.sv
module gpio_banked_ctrl_test;

    localparam int NB   = 2;
    localparam int AW   = 11;
    localparam int NP   = NB * 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];
    logic     rd_seen = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_banked_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Monitor: a read sampled on a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_seen) begin
            rd_item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL monitor: read with no expected item, actual %h", bus_rdata);
            end else begin
                it = exp_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL monitor: %0d reads never returned, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R11 reset state
        check({31'd0, irq}, 32'd0, "R11 irq after reset");
        check(pin_out[31:0] | pin_out[63:32], 32'd0, "R11 pin_out after reset");
        check(pin_oe[31:0] | pin_oe[63:32], 32'd0, "R11 pin_oe after reset");
        bus_read(11'h008, 32'd0, "R11 oe reg after reset");
        bus_read(11'h21C, 32'd0, "R11 raw bank1 after reset");

        // R1 data-out / enable per bank at 0x200 stride
        bus_write(11'h204, 32'hA5A5_0F0F);
        bus_write(11'h208, 32'hFFFF_0000);
        bus_write(11'h004, 32'h1234_5678);
        @(negedge clk);
        check(pin_out[63:32], 32'hA5A5_0F0F, "R1 bank1 pin_out");
        check(pin_oe[63:32], 32'hFFFF_0000, "R1 bank1 pin_oe");
        check(pin_out[31:0], 32'h1234_5678, "R1 bank0 pin_out");
        bus_read(11'h204, 32'hA5A5_0F0F, "R1 bank1 dout readback");
        bus_read(11'h208, 32'hFFFF_0000, "R1 bank1 oe readback");

        // R2 synchronized input read
        @(negedge clk); pin_in[5] = 1'b1; pin_in[40] = 1'b1;
        settle();
        bus_read(11'h000, 32'h0000_0020, "R2 bank0 din");
        bus_read(11'h200, 32'h0000_0100, "R2 bank1 din");
        bus_write(11'h000, 32'hFFFF_FFFF);
        bus_read(11'h000, 32'h0000_0020, "R2 din write ignored");
        @(negedge clk); pin_in[5] = 1'b0; pin_in[40] = 1'b0;
        settle();
        bus_read(11'h01C, 32'h0000_0020, "R4 default falling sense bank0");
        bus_write(11'h024, 32'hFFFF_FFFF);
        bus_write(11'h224, 32'hFFFF_FFFF);
        bus_read(11'h21C, 32'd0, "R7 bank1 cleared");

        // R3 rising edge, sticky
        bus_write(11'h014, 32'h0000_0008);
        bus_write(11'h018, 32'h0000_0008);
        @(negedge clk); pin_in[3] = 1'b1;
        settle();
        check({31'd0, irq}, 32'd1, "R3 irq after rising edge");
        bus_read(11'h01C, 32'h0000_0008, "R3 raw after rising edge");
        @(negedge clk); pin_in[3] = 1'b0;
        settle();
        bus_read(11'h01C, 32'h0000_0008, "R3 status sticky after pin low");
        bus_read(11'h020, 32'h0000_0008, "R8 masked status");
        bus_write(11'h024, 32'h0000_0008);
        @(negedge clk);
        check({31'd0, irq}, 32'd0, "R7 irq drops after clear");

        // R4 falling only
        bus_write(11'h014, 32'h0000_0000);
        @(negedge clk); pin_in[3] = 1'b1;
        settle();
        bus_read(11'h01C, 32'd0, "R4 rising ignored in falling mode");
        @(negedge clk); pin_in[3] = 1'b0;
        settle();
        bus_read(11'h01C, 32'h0000_0008, "R4 falling edge sets status");
        bus_write(11'h024, 32'h0000_0008);

        // R5 both edges on pin 34 (bank1 bit 2), polarity 0
        bus_write(11'h210, 32'h0000_0004);
        @(negedge clk); pin_in[34] = 1'b1;
        settle();
        bus_read(11'h21C, 32'h0000_0004, "R5 rising with both edges");
        bus_write(11'h224, 32'h0000_0004);
        @(negedge clk); pin_in[34] = 1'b0;
        settle();
        bus_read(11'h21C, 32'h0000_0004, "R5 falling with both edges");

        // R7 zero write has no effect, clear reads zero
        bus_write(11'h224, 32'h0000_0000);
        bus_read(11'h21C, 32'h0000_0004, "R7 zero clear keeps status");
        bus_read(11'h224, 32'd0, "R7 clear register reads zero");

        // R8 mask gating across banks
        check({31'd0, irq}, 32'd0, "R8 irq low while bank1 masked");
        bus_read(11'h220, 32'd0, "R8 bank1 masked status zero");
        bus_write(11'h218, 32'h0000_0006);
        @(negedge clk);
        check({31'd0, irq}, 32'd1, "R8 irq from bank1 once unmasked");
        bus_read(11'h220, 32'h0000_0004, "R8 bank1 masked = raw & enable");
        bus_write(11'h224, 32'h0000_0004);
        @(negedge clk);
        check({31'd0, irq}, 32'd0, "R8 irq low after bank1 clear");

        // R9 edge and clear in the same cycle
        @(negedge clk); pin_in[34] = 1'b1;
        settle();
        bus_read(11'h21C, 32'h0000_0004, "R9 setup status");
        @(negedge clk); pin_in[34] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        bus_write(11'h224, 32'h0000_0004);   // sampled on the edge the new event lands
        bus_read(11'h21C, 32'h0000_0004, "R9 event beats same-cycle clear");
        bus_write(11'h224, 32'h0000_0004);
        bus_read(11'h21C, 32'd0, "R9 later clear without event");
        bus_write(11'h218, 32'h0000_0000);

        // R6 level sensing: pin 10 high-active, pin 12 low-active
        bus_write(11'h014, 32'h0000_0400);
        bus_write(11'h00C, 32'h0000_1400);
        settle();
        bus_read(11'h01C, 32'h0000_1000, "R6 low level asserts status");
        @(negedge clk); pin_in[10] = 1'b1;
        settle();
        bus_read(11'h01C, 32'h0000_1400, "R6 high level asserts status");
        bus_write(11'h024, 32'h0000_1400);
        bus_read(11'h01C, 32'h0000_1400, "R6 status re-asserts after clear");
        bus_write(11'h00C, 32'h0000_0000);
        bus_write(11'h024, 32'h0000_1400);
        bus_read(11'h01C, 32'd0, "R6 cleared once level mode is off");

        // R10 unmapped space
        bus_read(11'h400, 32'd0, "R10 unimplemented bank reads zero");
        bus_read(11'h028, 32'd0, "R10 unmapped offset reads zero");
        bus_write(11'h604, 32'hFFFF_FFFF);
        @(negedge clk);
        check(pin_out[31:0], 32'h1234_5678, "R10 bank0 pin_out untouched");
        check(pin_out[63:32], 32'hA5A5_0F0F, "R10 bank1 pin_out untouched");
        bus_write(11'h21C, 32'hFFFF_FFFF);
        bus_read(11'h21C, 32'd0, "R10 raw status not writable");

        finish_run();
    end

endmodule